// File: doc/BRIEF.md
# Floating-Point Format Converter

This block takes a floating-point word in one parameterised format and produces the same value in a second format. Each format has its own exponent width and stored-fraction width. It re-biases the exponent, pads the fraction when the target has more fraction bits, and rounds to nearest (ties to even) when it has fewer. A result too large for the target becomes a signed infinity and raises an overflow flag. A result too small to be a normal number becomes a signed zero and raises an underflow flag. Denormal results are never produced.

When both formats are the same, the block still works as a conditioner. Denormal operands become signed zeros and every NaN becomes the one canonical quiet NaN. All other values pass through unchanged.

An operand is presented with a one-cycle valid strobe, and one may be presented every cycle. The result appears a fixed number of clock edges later, together with its own one-cycle valid strobe. The pipeline has three stages when either field of the target format is narrower than the source, and two stages otherwise.

Top module: `fp_fmt_convert`

## Requirements
- R1: With `in_vld` high at a rising edge, `out_vld` is high for exactly one cycle after the third rising edge counting that one if the exponent or fraction width shrinks, and after the second otherwise. Back-to-back inputs give back-to-back results, and reset clears `out_vld`.
- R2: Words are packed as sign in the MSB, then the biased exponent, then the stored fraction in the LSBs, with bias 2^(we-1)-1. A normal operand whose value fits is emitted with exponent e_in - bias_in + bias_out and no flag.
- R3: When the target fraction is wider, the source fraction is copied to the top bits and the lower bits are zero, so the conversion is exact.
- R4: When the target fraction is narrower, the fraction is rounded to nearest with ties to even. A carry out of the fraction increments the exponent and leaves a zero fraction.
- R5: Any NaN operand, quiet or signalling, gives sign 0, an all-ones exponent and a fraction with only its MSB set. Neither flag is raised.
- R6: When the rebiased exponent, after any rounding carry, is at or above the all-ones code, the result is an infinity with the operand's sign and `out_ovf` is 1. Flags are only ever high together with `out_vld`.
- R7: When the rebiased exponent, after any rounding carry, is zero or less, the result is a zero with the operand's sign and `out_udf` is 1. A value that rounds up to the smallest normal is not an underflow.
- R8: Zero and infinity operands map to zero and infinity of the same sign, with no flag.
- R9: Denormal operands (zero exponent, non-zero fraction) give a zero of the same sign and raise no flag. This includes the identical-format case.
- R10: With identical formats, every normal operand is reproduced bit for bit, including the largest and smallest normals, with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| in_word | input | 1+IN_EW+IN_FW | Operand in the source format |
| out_vld | output | 1 | Result strobe |
| out_word | output | 1+OUT_EW+OUT_FW | Result in the target format |
| out_ovf | output | 1 | Result saturated to infinity |
| out_udf | output | 1 | Result flushed to zero |

## Verification
Three instances are exercised: a narrowing one (8/23 to 5/10), an identical one (8/23 to 8/23) and a widening one (5/10 to 8/23). On the narrowing path, the operands sit just below, exactly at and just above a rounding tie, with odd and even kept LSBs, which separates round-to-nearest-even from truncation and from ties-away rounding. Operands whose rounding carry pushes them out of range, or lifts them into range, show that the range check is made after the carry. Denormals, quiet and signalling NaNs, signed zeros and infinities separate true special values from out-of-range normals. Pairs of back-to-back operands and checks one cycle early and one cycle late pin the stage count of each variant.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    // Operand class decided at unpack time and carried down the pipe
    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_NORM = 2'd1,
        CL_INF  = 2'd2,
        CL_NAN  = 2'd3
    } fclass_e;

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
#(
    parameter int IN_EW  = 8,
    parameter int IN_FW  = 23,
    parameter int OUT_EW = 5,
    parameter int EXW    = 10
) (
    input  logic [IN_EW+IN_FW:0] word_i,
    output logic                 sgn_o,
    output fclass_e              cls_o,
    output logic signed [EXW-1:0] exp_o,
    output logic [IN_FW-1:0]     frac_o
);

    localparam int BIAS_IN    = (1 << (IN_EW - 1)) - 1;
    localparam int BIAS_OUT   = (1 << (OUT_EW - 1)) - 1;
    localparam int BIAS_SHIFT = BIAS_OUT - BIAS_IN;

    logic [IN_EW-1:0] e_fld;
    logic [IN_FW-1:0] f_fld;

    assign sgn_o  = word_i[IN_EW+IN_FW];
    assign e_fld  = word_i[IN_FW +: IN_EW];
    assign f_fld  = word_i[IN_FW-1:0];
    assign frac_o = f_fld;

    // Denormals are folded into the zero class here (flush to zero)
    always_comb begin
        if (e_fld == '1)
            cls_o = (f_fld != '0) ? CL_NAN : CL_INF;
        else if (e_fld == '0)
            cls_o = CL_ZERO;
        else
            cls_o = CL_NORM;
    end

    // Rebias into a signed exponent wide enough to hold any out-of-range value
    assign exp_o = $signed({{(EXW-IN_EW){1'b0}}, e_fld}) + $signed(EXW'(BIAS_SHIFT));

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round #(
    parameter int IN_FW  = 23,
    parameter int OUT_FW = 10
) (
    input  logic [IN_FW-1:0]  frac_i,
    output logic [OUT_FW-1:0] frac_o,
    output logic              carry_o
);

    localparam int DROP = IN_FW - OUT_FW;

    generate
        if (OUT_FW >= IN_FW) begin : g_widen
            if (OUT_FW == IN_FW) begin : g_equal
                assign frac_o = frac_i;
            end else begin : g_pad
                assign frac_o = {frac_i, {(OUT_FW-IN_FW){1'b0}}};
            end
            assign carry_o = 1'b0;
        end else begin : g_narrow
            logic [OUT_FW-1:0] keep;
            logic              guard;
            logic              sticky;
            logic              bump;
            logic [OUT_FW:0]   sum;

            assign keep  = frac_i[IN_FW-1:DROP];
            assign guard = frac_i[DROP-1];
            if (DROP > 1) begin : g_sticky
                assign sticky = |frac_i[DROP-2:0];
            end else begin : g_no_sticky
                assign sticky = 1'b0;
            end

            // nearest, ties go to the even kept value
            assign bump    = guard & (sticky | keep[0]);
            assign sum     = {1'b0, keep} + (OUT_FW+1)'(bump);
            assign frac_o  = sum[OUT_FW-1:0];
            assign carry_o = sum[OUT_FW];
        end
    endgenerate

endmodule

// File: rtl/fcvt_pack.sv
module fcvt_pack
    import fcvt_pkg::*;
#(
    parameter int OUT_EW = 5,
    parameter int OUT_FW = 10,
    parameter int EXW    = 10
) (
    input  logic                  sgn_i,
    input  fclass_e               cls_i,
    input  logic signed [EXW-1:0] exp_i,
    input  logic [OUT_FW-1:0]     frac_i,
    input  logic                  carry_i,
    output logic [OUT_EW+OUT_FW:0] word_o,
    output logic                  ovf_o,
    output logic                  udf_o
);

    localparam logic signed [EXW-1:0] EXP_TOP   = EXW'((1 << OUT_EW) - 1);
    localparam logic signed [EXW-1:0] EXP_ONE   = EXW'(1);
    localparam logic [OUT_FW-1:0]     QNAN_FRAC = {1'b1, {(OUT_FW-1){1'b0}}};

    logic signed [EXW-1:0] e_fin;

    // Range is judged only after the rounding carry has been folded in
    assign e_fin = exp_i + $signed({{(EXW-1){1'b0}}, carry_i});

    always_comb begin
        word_o = '0;
        ovf_o  = 1'b0;
        udf_o  = 1'b0;
        case (cls_i)
            CL_ZERO: word_o = {sgn_i, {(OUT_EW+OUT_FW){1'b0}}};
            CL_INF:  word_o = {sgn_i, {OUT_EW{1'b1}}, {OUT_FW{1'b0}}};
            CL_NAN:  word_o = {1'b0, {OUT_EW{1'b1}}, QNAN_FRAC};
            default: begin
                if (e_fin >= EXP_TOP) begin
                    ovf_o  = 1'b1;
                    word_o = {sgn_i, {OUT_EW{1'b1}}, {OUT_FW{1'b0}}};
                end else if (e_fin < EXP_ONE) begin
                    udf_o  = 1'b1;
                    word_o = {sgn_i, {(OUT_EW+OUT_FW){1'b0}}};
                end else begin
                    word_o = {sgn_i, e_fin[OUT_EW-1:0], frac_i};
                end
            end
        endcase
    end

endmodule

// File: rtl/fp_fmt_convert.sv
module fp_fmt_convert
    import fcvt_pkg::*;
#(
    parameter int IN_EW  = 8,
    parameter int IN_FW  = 23,
    parameter int OUT_EW = 5,
    parameter int OUT_FW = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [IN_EW+IN_FW:0]    in_word,
    output logic                    out_vld,
    output logic [OUT_EW+OUT_FW:0]  out_word,
    output logic                    out_ovf,
    output logic                    out_udf
);

    localparam int  OUT_W   = 1 + OUT_EW + OUT_FW;
    localparam bit  NARROW  = (OUT_EW < IN_EW) || (OUT_FW < IN_FW);
    localparam int  LATENCY = NARROW ? 3 : 2;
    localparam int  EXW     = ((IN_EW > OUT_EW) ? IN_EW : OUT_EW) + 2;
    localparam logic [OUT_W-2:0]  INF_MAG   = {{OUT_EW{1'b1}}, {OUT_FW{1'b0}}};
    localparam logic [OUT_FW-1:0] QNAN_FRAC = {1'b1, {(OUT_FW-1){1'b0}}};

    typedef struct packed {
        logic                  vld;
        logic                  sgn;
        fclass_e               cls;
        logic signed [EXW-1:0] exp;
        logic [IN_FW-1:0]      frac;
    } unp_t;

    typedef struct packed {
        logic                  vld;
        logic                  sgn;
        fclass_e               cls;
        logic signed [EXW-1:0] exp;
        logic [OUT_FW-1:0]     frac;
        logic                  cry;
    } rnd_t;

    typedef struct packed {
        logic              vld;
        logic [OUT_W-1:0]  word;
        logic              ovf;
        logic              udf;
    } res_t;

    unp_t unp_d, unp_q;
    rnd_t rnd_d, rnd_s;
    res_t res_d, res_q;

    logic                  u_sgn;
    fclass_e               u_cls;
    logic signed [EXW-1:0] u_exp;
    logic [IN_FW-1:0]      u_frac;
    logic [OUT_FW-1:0]     r_frac;
    logic                  r_cry;
    logic [OUT_W-1:0]      p_word;
    logic                  p_ovf;
    logic                  p_udf;

    // ---------------- stage 1: classify and rebias ----------------
    fcvt_unpack #(
        .IN_EW (IN_EW),
        .IN_FW (IN_FW),
        .OUT_EW(OUT_EW),
        .EXW   (EXW)
    ) i_unpack (
        .word_i(in_word),
        .sgn_o (u_sgn),
        .cls_o (u_cls),
        .exp_o (u_exp),
        .frac_o(u_frac)
    );

    always_comb begin
        unp_d.vld  = in_vld;
        unp_d.sgn  = u_sgn;
        unp_d.cls  = u_cls;
        unp_d.exp  = u_exp;
        unp_d.frac = u_frac;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unp_q <= '0;
        else        unp_q <= unp_d;
    end

    // ---------------- stage 2: fraction resize ----------------
    fcvt_round #(
        .IN_FW (IN_FW),
        .OUT_FW(OUT_FW)
    ) i_round (
        .frac_i (unp_q.frac),
        .frac_o (r_frac),
        .carry_o(r_cry)
    );

    always_comb begin
        rnd_d.vld  = unp_q.vld;
        rnd_d.sgn  = unp_q.sgn;
        rnd_d.cls  = unp_q.cls;
        rnd_d.exp  = unp_q.exp;
        rnd_d.frac = r_frac;
        rnd_d.cry  = r_cry;
    end

    // Narrowing adds a register between rounding and range check
    generate
        if (NARROW) begin : g_mid_reg
            rnd_t rnd_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rnd_q <= '0;
                else        rnd_q <= rnd_d;
            end
            assign rnd_s = rnd_q;
        end else begin : g_mid_pass
            assign rnd_s = rnd_d;
        end
    endgenerate

    // ---------------- final stage: range check and pack ----------------
    fcvt_pack #(
        .OUT_EW(OUT_EW),
        .OUT_FW(OUT_FW),
        .EXW   (EXW)
    ) i_pack (
        .sgn_i  (rnd_s.sgn),
        .cls_i  (rnd_s.cls),
        .exp_i  (rnd_s.exp),
        .frac_i (rnd_s.frac),
        .carry_i(rnd_s.cry),
        .word_o (p_word),
        .ovf_o  (p_ovf),
        .udf_o  (p_udf)
    );

    always_comb begin
        res_d.vld  = rnd_s.vld;
        res_d.word = p_word;
        res_d.ovf  = rnd_s.vld & p_ovf;
        res_d.udf  = rnd_s.vld & p_udf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld  = res_q.vld;
    assign out_word = res_q.word;
    assign out_ovf  = res_q.ovf;
    assign out_udf  = res_q.udf;

    // ---------------- output checks ----------------
    logic [1:0] warm_d, warm_q;

    always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'(LATENCY)) |-> (out_vld == $past(in_vld, LATENCY)));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ovf && out_udf));

    assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_vld && out_word[OUT_W-2:0] == INF_MAG));

    assert_udf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_udf |-> (out_vld && out_word[OUT_W-2:0] == '0));

    assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_word[OUT_FW +: OUT_EW] == '1 && out_word[OUT_FW-1:0] != '0)
        |-> (out_word[OUT_FW-1:0] == QNAN_FRAC && !out_word[OUT_W-1] && !out_ovf && !out_udf));

endmodule

// File: tb/test_fp_fmt_convert.sv
module test_fp_fmt_convert;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // narrowing instance: 8/23 -> 5/10
    logic        nv = 1'b0;
    logic [31:0] na = '0;
    logic        n_ov, n_of, n_uf;
    logic [15:0] n_ow;

    fp_fmt_convert i_fp_fmt_convert (
        .clk(clk), .rst_n(rst_n), .in_vld(nv), .in_word(na),
        .out_vld(n_ov), .out_word(n_ow), .out_ovf(n_of), .out_udf(n_uf)
    );

    // identical-format instance: 8/23 -> 8/23
    logic        sv = 1'b0;
    logic [31:0] sa = '0;
    logic        s_ov, s_of, s_uf;
    logic [31:0] s_ow;

    fp_fmt_convert #(.IN_EW(8), .IN_FW(23), .OUT_EW(8), .OUT_FW(23)) i_fp_fmt_convert_same (
        .clk(clk), .rst_n(rst_n), .in_vld(sv), .in_word(sa),
        .out_vld(s_ov), .out_word(s_ow), .out_ovf(s_of), .out_udf(s_uf)
    );

    // widening instance: 5/10 -> 8/23
    logic        wv = 1'b0;
    logic [15:0] wa = '0;
    logic        w_ov, w_of, w_uf;
    logic [31:0] w_ow;

    fp_fmt_convert #(.IN_EW(5), .IN_FW(10), .OUT_EW(8), .OUT_FW(23)) i_fp_fmt_convert_wide (
        .clk(clk), .rst_n(rst_n), .in_vld(wv), .in_word(wa),
        .out_vld(w_ov), .out_word(w_ow), .out_ovf(w_of), .out_udf(w_uf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic vld, input logic [31:0] word,
                             input logic of, input logic uf, input logic [31:0] ew,
                             input bit eo, input bit eu);
        check(vld == 1'b1, req, "valid on time", {31'd0, vld}, 32'd1);
        check(word == ew, req, "word", word, ew);
        check({of, uf} == {eo, eu}, req, "flags ovf,udf", {30'd0, of, uf}, {30'd0, eo, eu});
    endtask

    // narrowing path: result after the third edge
    task automatic apply_n(input logic [31:0] a, input logic [15:0] ew,
                           input bit eo, input bit eu, input string req);
        @(negedge clk); nv = 1'b1; na = a;
        @(negedge clk); nv = 1'b0;
        @(negedge clk);
        check(n_ov == 1'b0, req, "no valid one cycle early", {31'd0, n_ov}, 32'd0);
        @(negedge clk);
        check_out(req, n_ov, {16'd0, n_ow}, n_of, n_uf, {16'd0, ew}, eo, eu);
    endtask

    task automatic apply_s(input logic [31:0] a, input logic [31:0] ew,
                           input bit eo, input bit eu, input string req);
        @(negedge clk); sv = 1'b1; sa = a;
        @(negedge clk); sv = 1'b0;
        check(s_ov == 1'b0, req, "no valid one cycle early", {31'd0, s_ov}, 32'd0);
        @(negedge clk);
        check_out(req, s_ov, s_ow, s_of, s_uf, ew, eo, eu);
    endtask

    task automatic apply_w(input logic [15:0] a, input logic [31:0] ew,
                           input bit eo, input bit eu, input string req);
        @(negedge clk); wv = 1'b1; wa = a;
        @(negedge clk); wv = 1'b0;
        check(w_ov == 1'b0, req, "no valid one cycle early", {31'd0, w_ov}, 32'd0);
        @(negedge clk);
        check_out(req, w_ov, w_ow, w_of, w_uf, ew, eo, eu);
    endtask

    task automatic test_reset;
        check({n_ov, s_ov, w_ov} == 3'b000, "R1", "valid low in reset",
              {29'd0, n_ov, s_ov, w_ov}, 32'd0);
        check({n_of, n_uf} == 2'b00, "R1", "flags low in reset", {30'd0, n_of, n_uf}, 32'd0);
    endtask

    task automatic test_latency;
        // back-to-back operands on the narrowing path
        @(negedge clk); nv = 1'b1; na = 32'h3F800000;
        @(negedge clk); na = 32'hC0200000;
        @(negedge clk); nv = 1'b0;
        @(negedge clk);
        check_out("R1", n_ov, {16'd0, n_ow}, n_of, n_uf, 32'h3C00, 1'b0, 1'b0);
        @(negedge clk);
        check_out("R1", n_ov, {16'd0, n_ow}, n_of, n_uf, 32'hC100, 1'b0, 1'b0);
        @(negedge clk);
        check(n_ov == 1'b0, "R1", "valid drops after burst", {31'd0, n_ov}, 32'd0);
        // single pulse on the two-stage path
        apply_s(32'h3F800000, 32'h3F800000, 1'b0, 1'b0, "R1");
        @(negedge clk);
        check(s_ov == 1'b0, "R1", "valid is one cycle wide", {31'd0, s_ov}, 32'd0);
    endtask

    task automatic test_rebias;
        apply_n(32'h3F800000, 16'h3C00, 1'b0, 1'b0, "R2");
        apply_n(32'hC0200000, 16'hC100, 1'b0, 1'b0, "R2");
        apply_n(32'h477FE000, 16'h7BFF, 1'b0, 1'b0, "R2");
        apply_n(32'h38800000, 16'h0400, 1'b0, 1'b0, "R2");
    endtask

    task automatic test_round;
        apply_n(32'h3F801000, 16'h3C00, 1'b0, 1'b0, "R4");  // tie, even kept -> down
        apply_n(32'h3F803000, 16'h3C02, 1'b0, 1'b0, "R4");  // tie, odd kept -> up
        apply_n(32'h3F801001, 16'h3C01, 1'b0, 1'b0, "R4");  // above tie -> up
        apply_n(32'h3F800FFF, 16'h3C00, 1'b0, 1'b0, "R4");  // below tie -> down
        apply_n(32'h3FFFF000, 16'h4000, 1'b0, 1'b0, "R4");  // carry into exponent
    endtask

    task automatic test_overflow;
        apply_n(32'h47800000, 16'h7C00, 1'b1, 1'b0, "R6");
        apply_n(32'hC7800000, 16'hFC00, 1'b1, 1'b0, "R6");
        apply_n(32'h477FF000, 16'h7C00, 1'b1, 1'b0, "R6");  // carry pushes it out
        apply_n(32'h7F000000, 16'h7C00, 1'b1, 1'b0, "R6");
    endtask

    task automatic test_underflow;
        apply_n(32'h38000000, 16'h0000, 1'b0, 1'b1, "R7");
        apply_n(32'hB8000000, 16'h8000, 1'b0, 1'b1, "R7");
        apply_n(32'h0D000000, 16'h0000, 1'b0, 1'b1, "R7");
        apply_n(32'h387FF000, 16'h0400, 1'b0, 1'b0, "R7");  // carry lifts it to min normal
    endtask

    task automatic test_specials;
        apply_n(32'h7FC00001, 16'h7E00, 1'b0, 1'b0, "R5");
        apply_n(32'hFF800001, 16'h7E00, 1'b0, 1'b0, "R5");
        apply_s(32'hFFC12345, 32'h7FC00000, 1'b0, 1'b0, "R5");
        apply_s(32'h7F800001, 32'h7FC00000, 1'b0, 1'b0, "R5");
        apply_w(16'h7E01, 32'h7FC00000, 1'b0, 1'b0, "R5");
        apply_n(32'h7F800000, 16'h7C00, 1'b0, 1'b0, "R8");
        apply_n(32'hFF800000, 16'hFC00, 1'b0, 1'b0, "R8");
        apply_n(32'h80000000, 16'h8000, 1'b0, 1'b0, "R8");
        apply_w(16'hFC00, 32'hFF800000, 1'b0, 1'b0, "R8");
        apply_s(32'h00000000, 32'h00000000, 1'b0, 1'b0, "R8");
    endtask

    task automatic test_denormal;
        apply_n(32'h00000001, 16'h0000, 1'b0, 1'b0, "R9");
        apply_n(32'h80400000, 16'h8000, 1'b0, 1'b0, "R9");
        apply_s(32'h807FFFFF, 32'h80000000, 1'b0, 1'b0, "R9");
        apply_w(16'h8001, 32'h80000000, 1'b0, 1'b0, "R9");
    endtask

    task automatic test_identity;
        apply_s(32'hC0490FDB, 32'hC0490FDB, 1'b0, 1'b0, "R10");
        apply_s(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 1'b0, "R10");
        apply_s(32'h00800000, 32'h00800000, 1'b0, 1'b0, "R10");
        apply_s(32'h3F800001, 32'h3F800001, 1'b0, 1'b0, "R10");
    endtask

    task automatic test_widen;
        apply_w(16'h3C00, 32'h3F800000, 1'b0, 1'b0, "R3");
        apply_w(16'hC100, 32'hC0200000, 1'b0, 1'b0, "R3");
        apply_w(16'h3C01, 32'h3F802000, 1'b0, 1'b0, "R3");
        apply_w(16'h7BFF, 32'h477FE000, 1'b0, 1'b0, "R3");
        apply_w(16'h0400, 32'h38800000, 1'b0, 1'b0, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_latency;
        test_rebias;
        test_round;
        test_overflow;
        test_underflow;
        test_specials;
        test_denormal;
        test_identity;
        test_widen;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule